// File: doc/BRIEF.md
# Legacy Configuration Address/Data Port Bridge

This block sits on the host side of a configuration path. It translates the two-register indirect configuration mechanism into single configuration cycle descriptions for targets on the local bus segment. Software first writes a packed selector into the address port: an enable bit, a bus number, a device number, a function number and a dword register index. Software then reads or writes the data port. Each data-port access that passes the checks becomes one Type 0 cycle description. That description is a 32-bit address pattern with one IDSEL line raised for the addressed device slot, plus the function and register fields, byte enables, a direction flag and write data.

Both edges of the block are valid/ready streams. The host request stream is accepted only while the bridge is idle. The block handles one access at a time. Its response is held until the host takes it. On the target side, the cycle description is held stable until the target accepts it. The target then returns one response pulse carrying read data and an abort flag. Some accesses cannot be forwarded: the selector is disabled, the bus number is nonzero, or the device has no IDSEL line. These accesses, and accesses to unmapped I/O addresses, are answered locally without a target cycle. A local or aborted read returns all ones.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the selector register reads 0x00000000, `io_req_ready` is 1, and both `cfg_req_valid` and `io_rsp_valid` are 0.
- R2: A write to the dword at I/O address 0x0CF8 updates only the byte lanes that are enabled. Bits 1:0 are always stored as zero. A read of 0x0CF8 returns the stored selector. The selector fields are: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 dword index.
- R3: A forwarded data-port access (dword at 0x0CFC) produces `cfg_req_ad` as follows. Bit (device+11) is the only bit set in bits 31:11. Bits 10:8 carry the function and bits 7:2 carry the dword index. Bits 1:0 are zero.
- R4: Byte enables come from the size code and address bits 1:0. Size 0 (byte) gives 0001 shifted left by the address bits. Size 1 (word) gives 0011 shifted left, truncated to 4 bits. Sizes 2 and 3 give 1111.
- R5: On a forwarded write, `cfg_req_write` is 1 and `cfg_req_wdata` equals the host write data. On a forwarded read, `cfg_req_write` is 0.
- R6: A forwarded read returns `cfg_rsp_rdata`. If `cfg_rsp_abort` is set, it returns 0xFFFFFFFF. Every write response carries 0x00000000.
- R7: While selector bit 31 is clear, data-port accesses raise no target cycle. Reads return 0xFFFFFFFF.
- R8: A device number above 20 raises no target cycle. The read returns 0xFFFFFFFF.
- R9: A nonzero bus number raises no target cycle. The read returns 0xFFFFFFFF.
- R10: An I/O address outside 0x0CF8–0x0CFF leaves the selector unchanged and raises no target cycle. A read there returns 0xFFFFFFFF.
- R11: `io_req_ready` is 1 only when no access is in progress. The `cfg_req_*` fields are held while `cfg_req_ready` is 0. `io_rsp_valid` and `io_rsp_rdata` are held while `io_rsp_ready` is 0.
- R12: A locally answered access has `io_rsp_valid` one cycle after acceptance. A forwarded access raises `cfg_req_valid` one cycle after acceptance. Its response follows one cycle after the target response pulse. With a zero-wait target, the total is 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_valid | input | 1 | Host access request valid |
| io_req_ready | output | 1 | Bridge idle and able to accept |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_addr | input | 16 | Host I/O byte address |
| io_req_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| io_req_wdata | input | 32 | Lane-aligned write data |
| io_rsp_valid | output | 1 | Host response valid |
| io_rsp_ready | input | 1 | Host takes response |
| io_rsp_rdata | output | 32 | Read data (zero for writes) |
| cfg_req_valid | output | 1 | Configuration cycle description valid |
| cfg_req_ready | input | 1 | Target accepts description |
| cfg_req_write | output | 1 | Cycle direction |
| cfg_req_ad | output | 32 | IDSEL, function and register pattern |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_wdata | output | 32 | Write data |
| cfg_rsp_valid | input | 1 | Target response pulse |
| cfg_rsp_abort | input | 1 | No target answered |
| cfg_rsp_rdata | input | 32 | Target read data |

## Verification
A locally answered access must show its response one cycle after the accepting edge. A forwarded access must show its request one cycle after acceptance and its response one cycle after the target pulse, so the minimum total is three cycles. A behavioural model in the bench is advanced on every rising edge from the same inputs. Every output is compared against that model at the following falling edge, so each result is checked in exactly the cycle it is due. In addition, each access task counts the cycles from acceptance to response and compares the count with three plus the programmed target waits.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;
  // Selector field layout (decoded by software and by this block)
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FN_W      = 3;
  localparam int DWORD_W   = 6;
  localparam int EN_BIT    = 31;
  localparam int BUS_LSB   = 16;
  localparam int DEV_LSB   = 11;
  localparam int FN_LSB    = 8;
  localparam int DWORD_LSB = 2;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_WORD = 2'd1;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_REPLY = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic               enable;
    logic [BUS_W-1:0]   bus;
    logic [DEV_W-1:0]   dev;
    logic [FN_W-1:0]    fn;
    logic [DWORD_W-1:0] dword;
  } cfg_sel_t;
endpackage

// File: rtl/cfgbr_lane_be.sv
module cfgbr_lane_be #(
  parameter int BE_W      = 4,
  parameter int LANE_BITS = 2
) (
  input  logic [LANE_BITS-1:0] lo_addr,
  input  logic [1:0]           size,
  output logic [BE_W-1:0]      be
);
  import cfgbr_pkg::*;

  logic [BE_W-1:0] base;

  always_comb begin
    case (size)
      SIZE_BYTE: base = {{(BE_W-1){1'b0}}, 1'b1};
      SIZE_WORD: base = {{(BE_W-2){1'b0}}, 2'b11};
      default:   base = '1;
    endcase
    if (size == SIZE_BYTE || size == SIZE_WORD) be = base << lo_addr;
    else                                        be = '1;
  end
endmodule

// File: rtl/cfgbr_addr_reg.sv
module cfgbr_addr_reg #(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W/8-1:0]  be,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    value,
  output cfgbr_pkg::cfg_sel_t  sel
);
  import cfgbr_pkg::*;

  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] wmasked;
  assign wmasked = {wdata[DATA_W-1:2], 2'b00};

  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                value[8*l +: 8] <= '0;
      else if (wr_en && be[l])   value[8*l +: 8] <= wmasked[8*l +: 8];
    end
  end

  assign sel.enable = value[EN_BIT];
  assign sel.bus    = value[BUS_LSB +: BUS_W];
  assign sel.dev    = value[DEV_LSB +: DEV_W];
  assign sel.fn     = value[FN_LSB +: FN_W];
  assign sel.dword  = value[DWORD_LSB +: DWORD_W];

  // R10: selector only changes on an enabled write
  assert_areg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(value));
  // R2: the two low bits never hold a one
  assert_areg_lowzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> value[1:0] == 2'b00);
endmodule

// File: rtl/cfgbr_idsel_enc.sv
module cfgbr_idsel_enc #(
  parameter int AD_W      = 32,
  parameter int IDSEL_LSB = 11,
  parameter int NUM_SLOTS = 21
) (
  input  logic [cfgbr_pkg::DEV_W-1:0]   dev,
  input  logic [cfgbr_pkg::FN_W-1:0]    fn,
  input  logic [cfgbr_pkg::DWORD_W-1:0] dword,
  output logic [AD_W-1:0]               ad,
  output logic                          reachable
);
  import cfgbr_pkg::*;

  localparam int SLOT_TOP = IDSEL_LSB + NUM_SLOTS;

  logic [NUM_SLOTS-1:0] hot;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign hot[s] = (dev == DEV_W'(s));
  end

  assign reachable = |hot;

  always_comb begin
    ad = '0;
    ad[IDSEL_LSB +: NUM_SLOTS] = hot;
    ad[FN_LSB +: FN_W]         = fn;
    ad[DWORD_LSB +: DWORD_W]   = dword;
  end

  initial begin
    if (SLOT_TOP > AD_W) $error("IDSEL slots exceed address width");
  end
endmodule

// File: rtl/cfgbr_seq.sv
module cfgbr_seq #(
  parameter int DATA_W = 32,
  parameter int AD_W   = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req_valid,
  output logic              io_req_ready,
  input  logic              io_req_write,
  input  logic [DATA_W-1:0] io_req_wdata,
  input  logic              fwd,
  input  logic [AD_W-1:0]   fwd_ad,
  input  logic [BE_W-1:0]   fwd_be,
  input  logic [DATA_W-1:0] local_rdata,
  output logic              io_rsp_valid,
  input  logic              io_rsp_ready,
  output logic [DATA_W-1:0] io_rsp_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [AD_W-1:0]   cfg_req_ad,
  output logic [BE_W-1:0]   cfg_req_be,
  output logic [DATA_W-1:0] cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic              cfg_rsp_abort,
  input  logic [DATA_W-1:0] cfg_rsp_rdata
);
  import cfgbr_pkg::*;

  seq_state_t        state;
  logic [AD_W-1:0]   ad_q;
  logic [BE_W-1:0]   be_q;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      ad_q  <= '0;
      be_q  <= '0;
      wr_q  <= 1'b0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (io_req_valid) begin
          if (fwd) begin
            ad_q  <= fwd_ad;
            be_q  <= fwd_be;
            wr_q  <= io_req_write;
            wd_q  <= io_req_wdata;
            state <= SEQ_ISSUE;
          end else begin
            rd_q  <= local_rdata;
            state <= SEQ_REPLY;
          end
        end
        SEQ_ISSUE: if (cfg_req_ready) state <= SEQ_WAIT;
        SEQ_WAIT: if (cfg_rsp_valid) begin
          if (wr_q)               rd_q <= '0;
          else if (cfg_rsp_abort) rd_q <= '1;
          else                    rd_q <= cfg_rsp_rdata;
          state <= SEQ_REPLY;
        end
        SEQ_REPLY: if (io_rsp_ready) state <= SEQ_IDLE;
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign io_req_ready  = (state == SEQ_IDLE);
  assign cfg_req_valid = (state == SEQ_ISSUE);
  assign io_rsp_valid  = (state == SEQ_REPLY);
  assign cfg_req_ad    = ad_q;
  assign cfg_req_be    = be_q;
  assign cfg_req_write = wr_q;
  assign cfg_req_wdata = wd_q;
  assign io_rsp_rdata  = rd_q;

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_ad)
      && $stable(cfg_req_be) && $stable(cfg_req_write) && $stable(cfg_req_wdata));
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid && !io_rsp_ready |=> io_rsp_valid && $stable(io_rsp_rdata));
  assert_abort_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == SEQ_WAIT && cfg_rsp_valid && cfg_rsp_abort && !wr_q
      |=> io_rsp_valid && io_rsp_rdata == '1);
  assert_issue_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_valid) |-> $past(io_req_valid && io_req_ready));
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int          IO_AW     = 16,
  parameter int          DATA_W    = 32,
  parameter int          AD_W      = 32,
  parameter int          IDSEL_LSB = 11,
  parameter int          NUM_SLOTS = 21,
  parameter int unsigned ADDR_PORT = 32'h0CF8,
  parameter int unsigned DATA_PORT = 32'h0CFC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_req_valid,
  output logic                 io_req_ready,
  input  logic                 io_req_write,
  input  logic [IO_AW-1:0]     io_req_addr,
  input  logic [1:0]           io_req_size,
  input  logic [DATA_W-1:0]    io_req_wdata,
  output logic                 io_rsp_valid,
  input  logic                 io_rsp_ready,
  output logic [DATA_W-1:0]    io_rsp_rdata,
  output logic                 cfg_req_valid,
  input  logic                 cfg_req_ready,
  output logic                 cfg_req_write,
  output logic [AD_W-1:0]      cfg_req_ad,
  output logic [DATA_W/8-1:0]  cfg_req_be,
  output logic [DATA_W-1:0]    cfg_req_wdata,
  input  logic                 cfg_rsp_valid,
  input  logic                 cfg_rsp_abort,
  input  logic [DATA_W-1:0]    cfg_rsp_rdata
);
  import cfgbr_pkg::*;

  localparam int BE_W      = DATA_W / 8;
  localparam int LANE_BITS = $clog2(BE_W);
  localparam logic [IO_AW-1:0] ADDR_HIT = IO_AW'(ADDR_PORT);
  localparam logic [IO_AW-1:0] DATA_HIT = IO_AW'(DATA_PORT);

  logic              accept, hit_addr, hit_data, reach, fwd;
  logic [BE_W-1:0]   be;
  logic [DATA_W-1:0] sel_value, local_rdata;
  logic [AD_W-1:0]   fwd_ad;
  cfg_sel_t          sel;

  assign accept   = io_req_valid && io_req_ready;
  assign hit_addr = io_req_addr[IO_AW-1:LANE_BITS] == ADDR_HIT[IO_AW-1:LANE_BITS];
  assign hit_data = io_req_addr[IO_AW-1:LANE_BITS] == DATA_HIT[IO_AW-1:LANE_BITS];

  cfgbr_lane_be #(.BE_W(BE_W), .LANE_BITS(LANE_BITS)) u_be (
    .lo_addr (io_req_addr[LANE_BITS-1:0]),
    .size    (io_req_size),
    .be      (be)
  );

  cfgbr_addr_reg #(.DATA_W(DATA_W)) u_areg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (accept && io_req_write && hit_addr),
    .be    (be),
    .wdata (io_req_wdata),
    .value (sel_value),
    .sel   (sel)
  );

  cfgbr_idsel_enc #(.AD_W(AD_W), .IDSEL_LSB(IDSEL_LSB), .NUM_SLOTS(NUM_SLOTS)) u_idsel (
    .dev       (sel.dev),
    .fn        (sel.fn),
    .dword     (sel.dword),
    .ad        (fwd_ad),
    .reachable (reach)
  );

  assign fwd = hit_data && sel.enable && (sel.bus == '0) && reach;

  always_comb begin
    if (io_req_write)  local_rdata = '0;
    else if (hit_addr) local_rdata = sel_value;
    else               local_rdata = '1;
  end

  cfgbr_seq #(.DATA_W(DATA_W), .AD_W(AD_W), .BE_W(BE_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_req_valid  (io_req_valid),
    .io_req_ready  (io_req_ready),
    .io_req_write  (io_req_write),
    .io_req_wdata  (io_req_wdata),
    .fwd           (fwd),
    .fwd_ad        (fwd_ad),
    .fwd_be        (be),
    .local_rdata   (local_rdata),
    .io_rsp_valid  (io_rsp_valid),
    .io_rsp_ready  (io_rsp_ready),
    .io_rsp_rdata  (io_rsp_rdata),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_ready (cfg_req_ready),
    .cfg_req_write (cfg_req_write),
    .cfg_req_ad    (cfg_req_ad),
    .cfg_req_be    (cfg_req_be),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_abort (cfg_rsp_abort),
    .cfg_rsp_rdata (cfg_rsp_rdata)
  );

  assert_idsel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> $countones(cfg_req_ad[AD_W-1:IDSEL_LSB]) == 1
      && cfg_req_ad[1:0] == 2'b00);
  assert_be_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> cfg_req_be != '0);
  assert_no_fwd_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit_data && !sel.enable |=> !cfg_req_valid);
  // R8 and R9: unreachable slot or foreign bus never starts a cycle
  assert_no_fwd_unreach_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit_data && (sel.bus != '0 || !reach) |=> !cfg_req_valid);
endmodule

// File: tb/cfg_port_bridge_tb_top.sv
module cfg_port_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req_valid = 1'b0, io_req_write = 1'b0;
  logic [15:0] io_req_addr = '0;
  logic [1:0]  io_req_size = '0;
  logic [31:0] io_req_wdata = '0;
  logic        io_rsp_ready = 1'b0;
  logic        cfg_req_ready = 1'b0;
  logic        cfg_rsp_valid = 1'b0, cfg_rsp_abort = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;
  logic        io_req_ready, io_rsp_valid, cfg_req_valid, cfg_req_write;
  logic [31:0] io_rsp_rdata, cfg_req_ad, cfg_req_wdata;
  logic [3:0]  cfg_req_be;

  always #5 clk = ~clk;

  cfg_port_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_write(io_req_write), .io_req_addr(io_req_addr),
    .io_req_size(io_req_size), .io_req_wdata(io_req_wdata),
    .io_rsp_valid(io_rsp_valid), .io_rsp_ready(io_rsp_ready),
    .io_rsp_rdata(io_rsp_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_write(cfg_req_write), .cfg_req_ad(cfg_req_ad),
    .cfg_req_be(cfg_req_be), .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_abort(cfg_rsp_abort),
    .cfg_rsp_rdata(cfg_rsp_rdata)
  );

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_phase = 0;   // 0 idle, 1 issuing, 2 waiting, 3 replying
  logic [31:0] m_sel = '0, m_ad = '0, m_wd = '0, m_rd = '0;
  logic [3:0]  m_be = '0;
  logic        m_wr = 1'b0;

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd0) return 4'b0001 << lo;
    if (sz == 2'd1) return 4'b0011 << lo;
    return 4'b1111;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_sel = '0;
    end else begin
      case (m_phase)
        0: if (io_req_valid) begin
          logic [3:0] b;
          int dev, bus;
          b = exp_be(io_req_size, io_req_addr[1:0]);
          dev = int'(m_sel[15:11]);
          bus = int'(m_sel[23:16]);
          if (io_req_addr[15:2] == 14'h033E) begin
            m_rd = io_req_write ? 32'h0 : m_sel;
            if (io_req_write) begin
              for (int l = 0; l < 4; l++)
                if (b[l]) m_sel[8*l +: 8] = io_req_wdata[8*l +: 8];
              m_sel[1:0] = 2'b00;
            end
            m_phase = 3;
          end else if (io_req_addr[15:2] == 14'h033F && m_sel[31]
                       && bus == 0 && dev <= 20) begin
            m_ad = (32'h1 << (dev + 11)) | {21'h0, m_sel[10:8], m_sel[7:2], 2'b00};
            m_be = b; m_wr = io_req_write; m_wd = io_req_wdata;
            m_phase = 1;
          end else begin
            m_rd = io_req_write ? 32'h0 : 32'hFFFF_FFFF;
            m_phase = 3;
          end
        end
        1: if (cfg_req_ready) m_phase = 2;
        2: if (cfg_rsp_valid) begin
          m_rd = m_wr ? 32'h0 : (cfg_rsp_abort ? 32'hFFFF_FFFF : cfg_rsp_rdata);
          m_phase = 3;
        end
        default: if (io_rsp_ready) m_phase = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 io_req_ready", {31'h0, io_req_ready}, {31'h0, m_phase == 0});
      chk("R12 cfg_req_valid", {31'h0, cfg_req_valid}, {31'h0, m_phase == 1});
      chk("R12 io_rsp_valid", {31'h0, io_rsp_valid}, {31'h0, m_phase == 3});
      if (m_phase == 1) begin
        chk("R3 cfg_req_ad", cfg_req_ad, m_ad);
        chk("R4 cfg_req_be", {28'h0, cfg_req_be}, {28'h0, m_be});
        chk("R5 cfg_req_write", {31'h0, cfg_req_write}, {31'h0, m_wr});
        if (m_wr) chk("R5 cfg_req_wdata", cfg_req_wdata, m_wd);
      end
      if (m_phase == 3) chk("R6 io_rsp_rdata", io_rsp_rdata, m_rd);
    end
  end

  // ---------------- target responder ----------------
  int          t_rdy_dly = 0, t_rsp_dly = 0, t_state = 0, t_cnt = 0, hs_count = 0;
  logic        t_abort = 1'b0;
  logic [31:0] t_rdata = '0, cap_ad = '0, cap_wd = '0;
  logic [3:0]  cap_be = '0;
  logic        cap_wr = 1'b0;

  always @(negedge clk) begin
    case (t_state)
      0: begin
        cfg_rsp_valid <= 1'b0;
        if (cfg_req_valid) begin
          if (t_cnt >= t_rdy_dly) begin
            cfg_req_ready <= 1'b1;
            cap_ad = cfg_req_ad; cap_be = cfg_req_be;
            cap_wr = cfg_req_write; cap_wd = cfg_req_wdata;
            hs_count++; t_cnt = 0; t_state = 1;
          end else t_cnt++;
        end
      end
      1: begin
        cfg_req_ready <= 1'b0;
        if (t_cnt >= t_rsp_dly) begin
          cfg_rsp_valid <= 1'b1; cfg_rsp_abort <= t_abort; cfg_rsp_rdata <= t_rdata;
          t_cnt = 0; t_state = 2;
        end else t_cnt++;
      end
      default: begin
        cfg_rsp_valid <= 1'b0;
        t_state = 0;
      end
    endcase
  end

  // ---------------- host access ----------------
  task automatic access(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int stall,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    io_req_valid = 1'b1; io_req_write = wr; io_req_addr = a;
    io_req_size = sz; io_req_wdata = wd;
    while (!io_req_ready) @(negedge clk);
    @(negedge clk);
    io_req_valid = 1'b0;
    lat = 1;
    while (!io_rsp_valid) begin @(negedge clk); lat++; end
    repeat (stall) @(negedge clk);
    rd = io_rsp_rdata;
    io_rsp_ready = 1'b1;
    @(negedge clk);
    io_rsp_ready = 1'b0;
  endtask

  task automatic set_sel(input logic [31:0] v);
    logic [31:0] rd; int lat;
    access(1'b1, 16'h0CF8, 2'd2, v, 0, rd, lat);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL R12 watchdog actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat, hs0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'h0, io_req_ready}, 32'h1);
    chk("R1 no cfg valid", {31'h0, cfg_req_valid}, 32'h0);
    chk("R1 no rsp valid", {31'h0, io_rsp_valid}, 32'h0);
    access(1'b0, 16'h0CF8, 2'd2, 0, 0, rd, lat);
    chk("R1 selector reset value", rd, 32'h0);
    chk("R12 local latency", lat, 1);

    // enable, bus 0, dev 1, fn 2, index 3
    set_sel(32'h8000_0A0C);
    access(1'b0, 16'h0CF8, 2'd2, 0, 0, rd, lat);
    chk("R2 selector readback", rd, 32'h8000_0A0C);

    t_rdy_dly = 0; t_rsp_dly = 0; t_rdata = 32'h1234_5678; t_abort = 1'b0;
    access(1'b0, 16'h0CFC, 2'd2, 0, 0, rd, lat);
    chk("R6 forwarded read data", rd, 32'h1234_5678);
    chk("R3 idsel pattern", cap_ad, 32'h0000_120C);
    chk("R4 dword enables", {28'h0, cap_be}, 32'hF);
    chk("R12 zero-wait forward latency", lat, 3);

    t_rdy_dly = 2; t_rsp_dly = 3;
    access(1'b1, 16'h0CFE, 2'd0, 32'h00AB_0000, 0, rd, lat);
    chk("R4 byte lane 2", {28'h0, cap_be}, 32'h4);
    chk("R5 write flag", {31'h0, cap_wr}, 32'h1);
    chk("R5 write data", cap_wd, 32'h00AB_0000);
    chk("R6 write response zero", rd, 32'h0);
    chk("R12 delayed forward latency", lat, 8);

    t_rdy_dly = 0; t_rsp_dly = 1;
    access(1'b0, 16'h0CFE, 2'd1, 0, 0, rd, lat);
    chk("R4 upper word enables", {28'h0, cap_be}, 32'hC);
    chk("R5 read flag", {31'h0, cap_wr}, 32'h0);
    access(1'b0, 16'h0CFF, 2'd1, 0, 0, rd, lat);
    chk("R4 word truncated", {28'h0, cap_be}, 32'h8);

    t_abort = 1'b1; t_rsp_dly = 0;
    access(1'b0, 16'h0CFC, 2'd2, 0, 0, rd, lat);
    chk("R6 master abort ones", rd, 32'hFFFF_FFFF);
    t_abort = 1'b0;

    // highest reachable slot: dev 20, index 15
    set_sel(32'h8000_A03C);
    t_rdata = 32'hCAFE_0001;
    access(1'b0, 16'h0CFC, 2'd2, 0, 0, rd, lat);
    chk("R3 top slot pattern", cap_ad, 32'h8000_003C);
    chk("R6 top slot data", rd, 32'hCAFE_0001);

    set_sel(32'h8000_A800);  // dev 21
    hs0 = hs_count;
    access(1'b0, 16'h0CFC, 2'd2, 0, 0, rd, lat);
    chk("R8 dev21 read ones", rd, 32'hFFFF_FFFF);
    chk("R8 dev21 no cycle", hs_count - hs0, 0);

    set_sel(32'h8001_0800);  // bus 1, dev 1
    hs0 = hs_count;
    access(1'b0, 16'h0CFC, 2'd2, 0, 0, rd, lat);
    chk("R9 bus1 read ones", rd, 32'hFFFF_FFFF);
    chk("R9 bus1 no cycle", hs_count - hs0, 0);

    set_sel(32'h0000_0800);  // disabled
    hs0 = hs_count;
    access(1'b0, 16'h0CFC, 2'd2, 0, 0, rd, lat);
    chk("R7 disabled read ones", rd, 32'hFFFF_FFFF);
    access(1'b1, 16'h0CFC, 2'd2, 32'h5555_5555, 0, rd, lat);
    chk("R7 disabled no cycle", hs_count - hs0, 0);

    hs0 = hs_count;
    access(1'b1, 16'h0080, 2'd2, 32'hDEAD_BEEF, 0, rd, lat);
    access(1'b0, 16'h0070, 2'd2, 0, 0, rd, lat);
    chk("R10 unmapped read ones", rd, 32'hFFFF_FFFF);
    access(1'b0, 16'h0CF8, 2'd2, 0, 0, rd, lat);
    chk("R10 selector untouched", rd, 32'h0000_0800);
    chk("R10 no cycle", hs_count - hs0, 0);

    access(1'b1, 16'h0CF9, 2'd0, 32'h0000_1100, 0, rd, lat);
    access(1'b0, 16'h0CF8, 2'd2, 0, 0, rd, lat);
    chk("R2 byte lane merge", rd, 32'h0000_1100);
    set_sel(32'h8000_0803);
    access(1'b0, 16'h0CF8, 2'd2, 0, 0, rd, lat);
    chk("R2 low bits zero", rd, 32'h8000_0800);

    // back-pressure on both sides
    t_rdy_dly = 4; t_rsp_dly = 2; t_rdata = 32'h0BAD_F00D;
    access(1'b0, 16'h0CFC, 2'd2, 0, 3, rd, lat);
    chk("R11 stalled read data", rd, 32'h0BAD_F00D);
    chk("R11 stalled latency", lat, 9);
    access(1'b0, 16'h0CF8, 2'd2, 0, 4, rd, lat);
    chk("R11 stalled local data", rd, 32'h8000_0800);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule